// File: doc/BRIEF.md
# Dual-Edge Burst-Two SRAM with Split Read and Write Ports

This block is a cycle-accurate, synthesizable model of a synchronous static memory with a single-rate request bus and two one-way data buses that move data on both clock edges. Each request names a word pair, so the address is one bit narrower than a word address. A request moves two words: the even word of the pair first, then the odd word. At most one read or one write is accepted per rising edge. Read data leaves on its own output bus, and write data arrives on its own input bus. A read burst and a write burst can therefore be in flight in the same cycle, and the bus never has to turn around.

A write's two data words and their lane enables follow the request by one cycle, one word on each clock half. A read returns its words one and a half cycles after the request, with a valid flag high for both beats. The read path merges a write that is still waiting to be committed, so program order holds even for a read issued in the cycle right after a write. When the per-device load strobe is high the cycle is ignored. Several devices can then share the read/write select for depth expansion.

Top module: `ddr_sio_sram`

## Requirements
- R1: While `rst_n` is low, and after its release until a read burst is issued, `rvalid` is 0 and `rdata` is all zeros in both clock halves.
- R2: A read accepted at rising edge n puts word {addr,0} on `rdata` in the low half of cycle n+1, which follows the falling edge. It puts word {addr,1} in the high half of cycle n+2. `rvalid` is 1 in both of those halves.
- R3: In every clock half that carries no read beat, `rvalid` is 0 and `rdata` is all zeros.
- R4: For a write accepted at rising edge n, `wdata`/`bw_n` are taken at rising edge n+1 for word {addr,0} and at the falling edge of cycle n+1 for word {addr,1}.
- R5: Lane i covers bits [i*LANE_W +: LANE_W] of a word. A write updates lane i only when `bw_n[i]` is 0 in that beat. When `bw_n[i]` is 1, lane i keeps its earlier contents.
- R6: A rising edge with `ld_n` at 1 accepts no request: no stored word changes, and no read beat is produced, whatever `rw`, `addr`, `wdata` and `bw_n` carry.
- R7: With `ld_n` at 0, `rw` at 1 requests a read and `rw` at 0 requests a write; both are sampled at the rising edge.
- R8: Reads accepted on consecutive rising edges produce an unbroken beat stream: `rvalid` stays 1 in every half from the first beat to the last, and each beat carries its own burst's words.
- R9: A read of the same pair issued in the cycle right after a write returns the written lanes merged with the older contents, as though the write had already finished.
- R10: A write accepted in the cycle right after a read of the same pair does not affect that read, which returns the contents as they were before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; requests on the rising edge, data on both edges |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline (not the storage) |
| addr | input | ADDR_W | Word-pair address of the request |
| ld_n | input | 1 | Active-low load strobe; high means the cycle is ignored |
| rw | input | 1 | 1 = read, 0 = write |
| bw_n | input | LANES | Active-low lane write enables, one set per beat |
| wdata | input | LANES*LANE_W | Write data, one word per clock half |
| rdata | output | LANES*LANE_W | Read data, one word per clock half; zero when idle |
| rvalid | output | 1 | High in each half that carries a read beat |

## Verification
The bench builds the block with ADDR_W=3 (eight word pairs) and four 9-bit lanes. With so few pairs, random addresses collide often. As a result, back-to-back writes and reads to the same pair, bypass hits and reads that race a following write all occur many times in a short run. The 9-bit lanes put lane edges away from nibble boundaries, so a mask applied to the wrong bit range shows up in the read-back words.

// File: rtl/ddr_sio_pkg.sv
package ddr_sio_pkg;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_READ  = 2'd1,
    REQ_WRITE = 2'd2
  } req_kind_e;

  // Decode of the control pins seen at a rising edge.
  function automatic req_kind_e decode_req(input logic load_n, input logic rd_sel);
    if (load_n) return REQ_NONE;
    return rd_sel ? REQ_READ : REQ_WRITE;
  endfunction

endpackage

// File: rtl/sio_req_capture.sv
module sio_req_capture
  import ddr_sio_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  output req_kind_e         req_kind,
  output logic [ADDR_W-1:0] req_addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_kind <= REQ_NONE;
      req_addr <= '0;
    end else begin
      req_kind <= decode_req(ld_n, rw);
      if (!ld_n) req_addr <= addr;
    end
  end

  // R6: a deselected edge yields no request
  a_r6_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> (req_kind == REQ_NONE));

endmodule

// File: rtl/sio_write_path.sv
module sio_write_path
  import ddr_sio_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int DW    = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  req_kind_e         req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     wdata,
  input  logic [LANES-1:0]  bw_n,
  output logic              wp_valid,
  output logic [ADDR_W-1:0] wp_addr,
  output logic [DW-1:0]     wp_d0,
  output logic [LANES-1:0]  wp_en0,
  output logic [DW-1:0]     wp_d1,
  output logic [LANES-1:0]  wp_en1
);

  // First beat: rising edge one cycle after the request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_valid <= 1'b0;
      wp_addr  <= '0;
      wp_d0    <= '0;
      wp_en0   <= '0;
    end else begin
      wp_valid <= (req_kind == REQ_WRITE);
      if (req_kind == REQ_WRITE) begin
        wp_addr <= req_addr;
        wp_d0   <= wdata;
        wp_en0  <= ~bw_n;
      end
    end
  end

  // Second beat: falling edge of that same cycle.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_d1  <= '0;
      wp_en1 <= '0;
    end else if (wp_valid) begin
      wp_d1  <= wdata;
      wp_en1 <= ~bw_n;
    end
  end

  // R4: an accepted write owns the data bus in the following cycle
  a_r4_write_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind == REQ_WRITE) |=> wp_valid);

endmodule

// File: rtl/sio_array.sv
module sio_array
  import ddr_sio_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int DW    = LANE_W * LANES,
  localparam int WORDS = 2 ** (ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  req_kind_e         req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              wp_valid,
  input  logic [ADDR_W-1:0] wp_addr,
  input  logic [DW-1:0]     wp_d0,
  input  logic [LANES-1:0]  wp_en0,
  input  logic [DW-1:0]     wp_d1,
  input  logic [LANES-1:0]  wp_en1,
  output logic              rb_valid,
  output logic [DW-1:0]     rb_w0,
  output logic [DW-1:0]     rb_w1
);

  logic [DW-1:0] mem [WORDS];

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] base,
                                               input logic [DW-1:0] upd,
                                               input logic [LANES-1:0] en);
    logic [DW-1:0] r;
    r = base;
    for (int i = 0; i < LANES; i++)
      if (en[i]) r[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
    return r;
  endfunction

  // Named internal events for the checks.
  logic rd_fire;
  logic byp_hit;
  assign rd_fire = (req_kind == REQ_READ);
  assign byp_hit = rd_fire && wp_valid && (wp_addr == req_addr);

  logic [DW-1:0] rd_even, rd_odd;
  always_comb begin
    rd_even = lane_merge(mem[{req_addr, 1'b0}], wp_d0, wp_en0 & {LANES{byp_hit}});
    rd_odd  = lane_merge(mem[{req_addr, 1'b1}], wp_d1, wp_en1 & {LANES{byp_hit}});
  end

  // Commit of the pending write pair.
  always_ff @(posedge clk) begin
    if (rst_n && wp_valid) begin
      mem[{wp_addr, 1'b0}] <= lane_merge(mem[{wp_addr, 1'b0}], wp_d0, wp_en0);
      mem[{wp_addr, 1'b1}] <= lane_merge(mem[{wp_addr, 1'b1}], wp_d1, wp_en1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_valid <= 1'b0;
      rb_w0    <= '0;
      rb_w1    <= '0;
    end else begin
      rb_valid <= rd_fire;
      if (rd_fire) begin
        rb_w0 <= rd_even;
        rb_w1 <= rd_odd;
      end
    end
  end

  // R8: every accepted read loads the read buffer on the next edge
  a_r8_read_issue: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rb_valid);

  // R9: the read result matches the storage once the pending write is committed
  a_r9_read_sees_commit: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (rb_w0 == mem[{$past(req_addr), 1'b0}]) &&
                (rb_w1 == mem[{$past(req_addr), 1'b1}]));

endmodule

// File: rtl/sio_ddr_out.sv
module sio_ddr_out #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rb_valid,
  input  logic [DW-1:0] rb_w0,
  input  logic [DW-1:0] rb_w1,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic          lo_v, hi_v;
  logic [DW-1:0] lo_d, hi_d;

  // Even word leaves on the falling edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_v <= 1'b0;
      lo_d <= '0;
    end else begin
      lo_v <= rb_valid;
      lo_d <= rb_valid ? rb_w0 : '0;
    end
  end

  // Odd word leaves on the next rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_v <= 1'b0;
      hi_d <= '0;
    end else begin
      hi_v <= rb_valid;
      hi_d <= rb_valid ? rb_w1 : '0;
    end
  end

  assign rdata  = clk ? hi_d : lo_d;
  assign rvalid = clk ? hi_v : lo_v;

  // R2: a first beat is always followed by the second beat
  a_r2_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    lo_v |=> hi_v);

endmodule

// File: rtl/ddr_sio_sram.sv
module ddr_sio_sram
  import ddr_sio_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int DW    = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ld_n,
  input  logic              rw,
  input  logic [LANES-1:0]  bw_n,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rvalid
);

  req_kind_e         req_kind;
  logic [ADDR_W-1:0] req_addr;
  logic              wp_valid;
  logic [ADDR_W-1:0] wp_addr;
  logic [DW-1:0]     wp_d0, wp_d1;
  logic [LANES-1:0]  wp_en0, wp_en1;
  logic              rb_valid;
  logic [DW-1:0]     rb_w0, rb_w1;

  sio_req_capture #(.ADDR_W(ADDR_W)) u_req (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
    .req_kind(req_kind), .req_addr(req_addr)
  );

  sio_write_path #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_wr (
    .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .req_addr(req_addr),
    .wdata(wdata), .bw_n(bw_n),
    .wp_valid(wp_valid), .wp_addr(wp_addr),
    .wp_d0(wp_d0), .wp_en0(wp_en0), .wp_d1(wp_d1), .wp_en1(wp_en1)
  );

  sio_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
    .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .req_addr(req_addr),
    .wp_valid(wp_valid), .wp_addr(wp_addr),
    .wp_d0(wp_d0), .wp_en0(wp_en0), .wp_d1(wp_d1), .wp_en1(wp_en1),
    .rb_valid(rb_valid), .rb_w0(rb_w0), .rb_w1(rb_w1)
  );

  sio_ddr_out #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .rb_valid(rb_valid), .rb_w0(rb_w0), .rb_w1(rb_w1),
    .rdata(rdata), .rvalid(rvalid)
  );

endmodule

// File: tb/ddr_sio_sram_bench.sv
`timescale 1ns/1ps
module ddr_sio_sram_bench;

  localparam int AW = 3;
  localparam int LW = 9;
  localparam int NL = 4;
  localparam int DW = LW * NL;
  localparam int NPAIR = 2 ** AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ld_n = 1'b1;
  logic          rw = 1'b0;
  logic [NL-1:0] bw_n = '1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  always #2.5 clk = ~clk;

  ddr_sio_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u_ddr_sio_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ld_n(ld_n), .rw(rw),
    .bw_n(bw_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  string phase = "R1 reset";
  bit rand_mask = 0;

  // reference storage, indexed by word address
  logic [DW-1:0] ref_mem [2*NPAIR];

  // expected beats per cycle, ring of four slots
  bit            lo_v [4];
  bit            hi_v [4];
  logic [DW-1:0] lo_e [4];
  logic [DW-1:0] hi_e [4];

  // write beats owed to the data bus in the next cycle
  bit            pw_v = 0;
  logic [DW-1:0] pw_d0, pw_d1;
  logic [NL-1:0] pw_b0, pw_b1;

  function automatic logic [DW-1:0] rnd_word();
    return DW'({$urandom(), $urandom()});
  endfunction

  function automatic logic [DW-1:0] apply_lanes(input logic [DW-1:0] old,
                                                input logic [DW-1:0] nw,
                                                input logic [NL-1:0] b_n);
    logic [DW-1:0] res;
    for (int bit_i = 0; bit_i < DW; bit_i++)
      res[bit_i] = b_n[bit_i / LW] ? old[bit_i] : nw[bit_i];
    return res;
  endfunction

  task automatic expect_out(input bit v, input logic [DW-1:0] e);
    checks++;
    if (v) begin
      if (rvalid !== 1'b1 || rdata !== e) begin
        errors++;
        $display("FAIL R2 %s cyc=%0d: rvalid=%0b rdata=%h expected rvalid=1 rdata=%h",
                 phase, cyc, rvalid, rdata, e);
      end
    end else if (rvalid !== 1'b0 || rdata !== '0) begin
      errors++;
      $display("FAIL R3 %s cyc=%0d: rvalid=%0b rdata=%h expected rvalid=0 rdata=0",
               phase, cyc, rvalid, rdata);
    end
  endtask

  // One clock cycle: issue a request, feed owed write beats, check both halves.
  task automatic step(input logic ldn, input logic rdsel, input logic [AW-1:0] a);
    bit            cur_v;
    logic [DW-1:0] cur_d1;
    logic [NL-1:0] cur_b1;
    cur_v  = pw_v;
    cur_d1 = pw_d1;
    cur_b1 = pw_b1;
    ld_n = ldn; rw = rdsel; addr = a;
    if (cur_v) begin wdata = pw_d0; bw_n = pw_b0; end
    else begin wdata = rnd_word(); bw_n = NL'($urandom()); end
    pw_v = 0;
    if (!ldn && !rdsel) begin
      pw_v  = 1;
      pw_d0 = rnd_word();
      pw_d1 = rnd_word();
      pw_b0 = rand_mask ? NL'($urandom()) : '0;
      pw_b1 = rand_mask ? NL'($urandom()) : '0;
      ref_mem[{a, 1'b0}] = apply_lanes(ref_mem[{a, 1'b0}], pw_d0, pw_b0);
      ref_mem[{a, 1'b1}] = apply_lanes(ref_mem[{a, 1'b1}], pw_d1, pw_b1);
    end else if (!ldn && rdsel) begin
      lo_v[(cyc + 1) % 4] = 1;
      lo_e[(cyc + 1) % 4] = ref_mem[{a, 1'b0}];
      hi_v[(cyc + 2) % 4] = 1;
      hi_e[(cyc + 2) % 4] = ref_mem[{a, 1'b1}];
    end
    @(posedge clk); #1.25;
    expect_out(hi_v[cyc % 4], hi_e[cyc % 4]);
    hi_v[cyc % 4] = 0;
    if (cur_v) begin wdata = cur_d1; bw_n = cur_b1; end
    else begin wdata = rnd_word(); bw_n = NL'($urandom()); end
    @(negedge clk); #1.25;
    expect_out(lo_v[cyc % 4], lo_e[cyc % 4]);
    lo_v[cyc % 4] = 0;
    cyc++;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin lo_v[i] = 0; hi_v[i] = 0; end
    for (int i = 0; i < 2*NPAIR; i++) ref_mem[i] = '0;
    // R1: idle outputs during reset, in both halves
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1.25;
      checks++;
      if (rvalid !== 1'b0 || rdata !== '0) begin
        errors++;
        $display("FAIL R1 reset high half: rvalid=%0b rdata=%h expected 0/0", rvalid, rdata);
      end
      @(negedge clk); #1.25;
      checks++;
      if (rvalid !== 1'b0 || rdata !== '0) begin
        errors++;
        $display("FAIL R1 reset low half: rvalid=%0b rdata=%h expected 0/0", rvalid, rdata);
      end
    end
    rst_n = 1'b1;
    phase = "R1 after release";
    step(1, 0, '0); step(1, 1, '0);

    // R4: fill every pair with full-lane writes, the beats one cycle late
    phase = "R4 fill";
    for (int a = 0; a < NPAIR; a++) step(0, 0, AW'(a));
    step(1, 0, '0);

    // R2: isolated reads, idle halves in between (R3)
    phase = "R2 isolated read";
    for (int a = 0; a < NPAIR; a++) begin step(0, 1, AW'(a)); step(1, 1, '0); step(1, 0, '0); end

    // R8: a read on every edge
    phase = "R8 back-to-back reads";
    for (int a = 0; a < NPAIR; a++) step(0, 1, AW'(NPAIR - 1 - a));
    for (int a = 0; a < NPAIR; a++) step(0, 1, AW'(a));
    step(1, 0, '0); step(1, 0, '0);

    // R5: random lane masks, read back after a gap
    phase = "R5 lane masks";
    rand_mask = 1;
    for (int i = 0; i < 16; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom());
      step(0, 0, a); step(1, 0, '0); step(0, 1, a);
    end

    // R9: read right after a write to the same pair
    phase = "R9 bypass";
    for (int i = 0; i < 16; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom());
      step(0, 0, a); step(0, 1, a);
    end

    // R10: write right after a read of the same pair
    phase = "R10 read then write";
    for (int i = 0; i < 12; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom());
      step(0, 1, a); step(0, 0, a); step(0, 1, a);
    end

    // R6: deselected edges with live-looking controls and data
    phase = "R6 deselect";
    for (int i = 0; i < 16; i++) step(1, logic'($urandom()), AW'($urandom()));
    for (int a = 0; a < NPAIR; a++) begin step(1, 0, AW'(a)); step(0, 1, AW'(a)); end

    // R7: random mix of reads, writes and idle edges
    phase = "R7 mixed";
    for (int i = 0; i < 120; i++)
      step(logic'(($urandom() % 4) == 0), logic'($urandom()), AW'($urandom()));
    for (int a = 0; a < NPAIR; a++) step(0, 1, AW'(a));
    for (int i = 0; i < 4; i++) step(1, 0, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule